// File: doc/BRIEF.md
# Execution Trace Capture Buffer Controller

This block manages a small on-chip store that records program-execution trace bytes while the CPU is running. A trace source presents one byte per cycle with a valid strobe. The controller arms itself when the CPU's running indication rises. It writes the accepted bytes into a 256-entry buffer under one of two policies. In one-shot mode, capture stops when the buffer is full and a break request asks the CPU to halt. In wrap mode, the oldest bytes are overwritten, and the buffer always holds the newest history up to the moment the CPU halts.

Once the CPU is stopped, a host reads the buffer through a logical index. Index 0 is always the oldest retained byte, and a count output gives the number of valid bytes. When the continue-after-break option is set, a full one-shot buffer produces a resume request once the CPU has halted. The next running period then proceeds without re-arming, so the captured history is preserved for readout.

Top module: `trace_buf_ctrl`

## Requirements
- R1: After reset, count_o is 0, and brk_req_o and resume_o are low.
- R2: On a cycle where cpu_run_i rises, capture arms if auto_start_i is high, or if arm_req_i is high in that cycle, or if arm_req_i has pulsed since the last arming. Arming clears the buffer (count_o becomes 0), and the earliest byte that can be captured is the one presented in the following cycle. Without either condition, a rise arms nothing and the buffer keeps its contents.
- R3: A byte is stored only when capture is armed, cpu_run_i is high and trc_valid_i is high. Bytes presented while the CPU is stopped, or while capture is disarmed, change neither count_o nor the stored data.
- R4: In one-shot mode (mode_i = 0), storing the 256th byte raises brk_req_o for exactly one cycle, in the next cycle, and disarms capture.
- R5: A fall of cpu_run_i disarms capture. A run that stops before the buffer fills leaves count_o equal to the number of bytes stored.
- R6: In wrap mode (mode_i = 1), brk_req_o never rises. After 256 bytes, each new byte overwrites the oldest one, and count_o stays at 256.
- R7: rd_data_o gives the byte at logical index rd_idx_i one cycle after rd_idx_i is applied. Index 0 is the oldest retained byte and index count_o-1 is the newest.
- R8: count_o equals the number of bytes stored since arming, saturating at 256.
- R9: When resume_en_i is high at a one-shot full event, resume_o pulses for one cycle once cpu_run_i is low. The next rise of cpu_run_i does not arm, even with auto_start_i high, so the buffer and count are preserved.
- R10: With auto_start_i high, every rise of cpu_run_i, other than the one skipped under R9, re-arms and clears capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_run_i | input | 1 | CPU running indication |
| trc_valid_i | input | 1 | Trace byte valid |
| trc_data_i | input | 8 | Trace byte |
| mode_i | input | 1 | 0 one-shot (stop on full), 1 wrap (overwrite oldest) |
| auto_start_i | input | 1 | Arm on every running rise |
| arm_req_i | input | 1 | Arm at the next running rise |
| resume_en_i | input | 1 | Request resume after a one-shot full break |
| rd_idx_i | input | 8 | Logical read index, 0 = oldest |
| rd_data_o | output | 8 | Read data, one cycle after rd_idx_i |
| count_o | output | 9 | Number of valid bytes |
| brk_req_o | output | 1 | One-cycle break request on one-shot full |
| resume_o | output | 1 | One-cycle resume request after a halt |

## Verification
The bench targets the 256th-byte boundary in one-shot mode. A design that is off by one there would break a byte early or late, or would keep capturing in the cycle after the break. In wrap mode, a wrong oldest-entry base would rotate the readout, and a wrong saturation would let count_o fall back after the wrap. Bytes are driven while the CPU is stopped and across non-arming rises, to catch any leakage into the buffer. The resume path is exercised to catch a design that re-arms on the skipped rise and so erases the history it was meant to keep.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  typedef enum logic {
    CAP_ONESHOT = 1'b0,
    CAP_WRAP    = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/trc_arm_ctrl.sv
`timescale 1ns/1ps
module trc_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_run_i,
  input  logic auto_start_i,
  input  logic arm_req_i,
  input  logic resume_en_i,
  input  logic full_evt_i,
  output logic armed_o,
  output logic start_o,
  output logic resume_o
);
  logic run_q, arm_pend_q, res_pend_q, skip_q;
  logic rise, halted_pend;

  assign rise        = cpu_run_i & ~run_q;
  assign start_o     = rise & (auto_start_i | arm_pend_q | arm_req_i) & ~skip_q;
  assign halted_pend = res_pend_q & ~cpu_run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      arm_pend_q <= 1'b0;
      armed_o    <= 1'b0;
      res_pend_q <= 1'b0;
      skip_q     <= 1'b0;
      resume_o   <= 1'b0;
    end else begin
      run_q <= cpu_run_i;
      if (start_o)        arm_pend_q <= 1'b0;
      else if (arm_req_i) arm_pend_q <= 1'b1;
      if (start_o)                            armed_o <= 1'b1;
      else if (!cpu_run_i || full_evt_i)      armed_o <= 1'b0;
      if (full_evt_i && resume_en_i) res_pend_q <= 1'b1;
      else if (halted_pend)          res_pend_q <= 1'b0;
      if (halted_pend) skip_q <= 1'b1;
      else if (rise)   skip_q <= 1'b0;
      resume_o <= halted_pend;
    end
  end

  // R5: a stopped CPU leaves capture disarmed
  p_disarm_on_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_run_i |=> !armed_o);
  // R9: resume request is a single pulse
  p_resume_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  // R9: the rise after a resume never arms
  p_skip_no_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o && !cpu_run_i |=> !start_o || !cpu_run_i);
endmodule

// File: rtl/trc_wr_ptr.sv
`timescale 1ns/1ps
module trc_wr_ptr #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_en_i,
  input  logic          wrap_mode_i,
  output logic [AW-1:0] wptr_o,
  output logic          wrapped_o,
  output logic [CW-1:0] count_o,
  output logic          full_evt_o,
  output logic          brk_req_o
);
  logic last;

  assign last       = (wptr_o == AW'(DEPTH - 1));
  assign full_evt_o = wr_en_i & last & ~wrap_mode_i;
  assign count_o    = wrapped_o ? CW'(DEPTH) : CW'(wptr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o    <= '0;
      wrapped_o <= 1'b0;
      brk_req_o <= 1'b0;
    end else begin
      brk_req_o <= full_evt_o;
      if (start_i) begin
        wptr_o    <= '0;
        wrapped_o <= 1'b0;
      end else if (wr_en_i) begin
        wptr_o <= last ? '0 : wptr_o + AW'(1);
        if (last) wrapped_o <= 1'b1;
      end
    end
  end

  // R8: count never exceeds capacity
  p_count_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  // R4: break request is a single pulse
  p_brk_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |=> !brk_req_o);
  // R6: a write in wrap mode never breaks
  p_wrap_no_brk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wrap_mode_i |=> !brk_req_o);
  // R3: pointer only moves on a write or arming
  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !start_i |=> $stable(wptr_o));
endmodule

// File: rtl/trc_store.sv
`timescale 1ns/1ps
module trc_store #(
  parameter int DEPTH = 256,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   sum;
  logic [AW-1:0] raddr;

  // logical index -> physical slot, modulo DEPTH
  assign sum   = {1'b0, base_i} + {1'b0, rd_idx_i};
  assign raddr = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : AW'(sum);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem[raddr];
  end
endmodule

// File: rtl/trace_buf_ctrl.sv
`timescale 1ns/1ps
module trace_buf_ctrl #(
  parameter int DEPTH = 256,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_run_i,
  input  logic          trc_valid_i,
  input  logic [DW-1:0] trc_data_i,
  input  logic          mode_i,
  input  logic          auto_start_i,
  input  logic          arm_req_i,
  input  logic          resume_en_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          brk_req_o,
  output logic          resume_o
);
  import trc_pkg::*;

  cap_mode_e     mode;
  logic          armed, start, wr_en, full_evt, wrapped;
  logic [AW-1:0] wptr, base;

  assign mode  = cap_mode_e'(mode_i);
  assign wr_en = armed & cpu_run_i & trc_valid_i;
  assign base  = wrapped ? wptr : '0;

  trc_arm_ctrl u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_run_i(cpu_run_i),
    .auto_start_i(auto_start_i), .arm_req_i(arm_req_i),
    .resume_en_i(resume_en_i), .full_evt_i(full_evt),
    .armed_o(armed), .start_o(start), .resume_o(resume_o)
  );

  trc_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .wr_en_i(wr_en),
    .wrap_mode_i(mode == CAP_WRAP), .wptr_o(wptr), .wrapped_o(wrapped),
    .count_o(count_o), .full_evt_o(full_evt), .brk_req_o(brk_req_o)
  );

  trc_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .waddr_i(wptr),
    .wdata_i(trc_data_i), .base_i(base), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  // R3: no capture while the CPU is stopped
  p_no_cap_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_run_i |=> $stable(count_o) || count_o == '0);
endmodule

// File: tb/trace_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module trace_buf_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0, valid = 1'b0, mode = 1'b0, auto = 1'b0, arm = 1'b0, res_en = 1'b0;
  logic [7:0] data = '0, rd_idx = '0;
  logic [7:0] rd_data;
  logic [8:0] count;
  logic       brk, resume;

  int errors = 0, checks = 0;
  bit chk_en = 0, done = 0;

  always #2.5 clk = ~clk;

  trace_buf_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_run_i(run), .trc_valid_i(valid),
    .trc_data_i(data), .mode_i(mode), .auto_start_i(auto), .arm_req_i(arm),
    .resume_en_i(res_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .count_o(count), .brk_req_o(brk), .resume_o(resume)
  );

  // requirement-level reference
  logic [7:0] m_buf [256];
  int  m_w = 0;
  bit  m_wrap = 0, m_arm = 0, m_runq = 0, m_pend = 0, m_res = 0, m_skip = 0;
  bit  m_brk = 0, m_resume = 0;

  function automatic int exp_count();
    return m_wrap ? 256 : m_w;
  endfunction

  function automatic logic [7:0] exp_byte(int i);
    return m_wrap ? m_buf[(m_w + i) % 256] : m_buf[i];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit rise, start, wr, full, halted;
      rise   = run && !m_runq;
      start  = rise && (auto || m_pend || arm) && !m_skip;   // R2
      wr     = m_arm && run && valid;                         // R3
      full   = wr && m_w == 255 && !mode;                     // R4
      halted = m_res && !run;
      if (start) begin m_w = 0; m_wrap = 0; end
      else if (wr) begin
        m_buf[m_w] = data;
        if (m_w == 255) begin m_w = 0; m_wrap = 1; end else m_w++;
      end
      m_brk = full;
      m_resume = halted;
      if (start) m_pend = 0; else if (arm) m_pend = 1;
      if (start) m_arm = 1; else if (!run || full) m_arm = 0;
      if (full && res_en) m_res = 1; else if (halted) m_res = 0;
      if (halted) m_skip = 1; else if (rise) m_skip = 0;
      m_runq = run;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R8 / R4 / R9 cycle-by-cycle
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk(count == 9'(exp_count()), "R8 count_o", count, exp_count());
      chk(brk == m_brk, "R4 brk_req_o", brk, m_brk);
      chk(resume == m_resume, "R9 resume_o", resume, m_resume);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = ($urandom_range(0, 9) < 7);
      data  = 8'($urandom);
    end
  endtask

  task automatic readout(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_idx = 8'(i);
      @(negedge clk);
      chk(rd_data == exp_byte(i), tag, rd_data, exp_byte(i));
    end
  endtask

  task automatic run_until_brk(string tag);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      cyc(1);
      if (brk) seen = 1;
    end
    chk(seen, tag, seen, 1);
  endtask

  initial begin
    automatic int saved;
    automatic logic [7:0] s0;
    automatic bit any_brk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count at reset", count, 0);
    chk(brk == 0 && resume == 0, "R1 requests at reset", {brk, resume}, 0);
    rst_n = 1'b1;
    chk_en = 1;
    cyc(2);

    // R4 one-shot fill with auto start (R10)
    mode = 0; auto = 1;
    @(negedge clk); run = 1;
    run_until_brk("R4 break on 256th byte");
    chk(count == 256, "R4 count at full", count, 256);
    cyc(5);                                  // running after break: nothing captured
    chk(count == 256, "R4 disarmed after full", count, 256);
    run = 0;
    readout(256, "R7 one-shot readout");
    cyc(20);                                 // R3 bytes while stopped
    readout(4, "R3 stopped bytes discarded");

    // R5 early stop
    @(negedge clk); run = 1;
    cyc(60);
    run = 0;
    cyc(2);
    chk(count < 256 && count > 0, "R5 partial count", count, exp_count());
    readout(exp_count(), "R5 partial readout");

    // R6 wrap mode
    mode = 1; any_brk = 0;
    @(negedge clk); run = 1;
    for (int i = 0; i < 700; i++) begin cyc(1); if (brk) any_brk = 1; end
    chk(!any_brk, "R6 no break in wrap", any_brk, 0);
    chk(count == 256, "R6 count saturates", count, 256);
    run = 0;
    cyc(2);
    readout(256, "R6 oldest-first after wrap");

    // R2 no arming without auto start or request
    auto = 0; saved = count; s0 = exp_byte(0);
    @(negedge clk); run = 1;
    cyc(40);
    run = 0;
    cyc(2);
    chk(count == 9'(saved), "R2 no arm keeps count", count, saved);
    readout(1, "R2 no arm keeps data");
    chk(exp_byte(0) == s0, "R2 model data held", exp_byte(0), s0);

    // R2 explicit arm request
    mode = 0;
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    cyc(3);
    run = 1;
    cyc(30);
    run = 0;
    cyc(2);
    chk(count < 256, "R2 arm request restarts", count, exp_count());
    readout(exp_count(), "R2 readout after request");

    // R9 continue after break
    auto = 1; res_en = 1;
    @(negedge clk); run = 1;
    run_until_brk("R9 break before resume");
    run = 0;
    cyc(1);
    chk(resume == 1, "R9 resume pulse", resume, 1);
    run = 1;
    cyc(40);
    chk(count == 256, "R9 no re-arm on resume", count, 256);
    run = 0;
    cyc(2);
    readout(256, "R9 history preserved");
    res_en = 0;
    @(negedge clk); run = 1;
    cyc(25);
    run = 0;
    cyc(2);
    chk(count < 256, "R10 re-arm on next rise", count, exp_count());
    readout(exp_count(), "R10 readout");

    chk_en = 0;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule